// File: doc/BRIEF.md
# Trace Port Cycle Packer

This block sits between a processor trace port and a capture memory. Every clock cycle in which the trace port presents a sample, the block receives a 3-bit pipeline status, a packet field and a sync flag. It places these into fixed lanes of a 32-bit capture word, so that a narrow port shares one memory word among several cycles. A 4-bit port puts three cycles into a word, an 8-bit port two, and a 16-bit port one. When a sample is flagged as the trigger cycle, the block marks it in the status field with a reserved code and keeps the real status in the low packet bits. This costs no extra storage bit.

The port configuration has two parts, width and port mode. It is captured only while capture is off. Configurations the capture path cannot take are flagged and no samples are accepted while they are in force. When capture is switched off with a partly filled word, that word is pushed out with its empty lanes at zero. Each finished word comes with a one-cycle valid strobe.

Top module: `trc_cycle_packer`

## Requirements
- R1: After reset, `word_vld` is 0, `word_o` is 0, `cfg_bad` is 0, and the configuration is 16-bit width in normal port mode.
- R2: With `width_sel`=00 (4-bit), accepted cycle k (k=0,1,2) occupies bits 8k+7..8k. Status is in 8k+2..8k, packet bits 3..0 are in 8k+6..8k+3, and sync is in 8k+7. A word is emitted after the third cycle, with bits 31..24 zero.
- R3: With `width_sel`=01 (8-bit), accepted cycle k (k=0,1) occupies bits 12k+11..12k. Status is in 12k+2..12k, packet bits 7..0 are in 12k+10..12k+3, and sync is in 12k+11. A word is emitted after the second cycle, with bits 31..24 zero.
- R4: With `width_sel`=10 (16-bit), every accepted cycle emits a word. Status is in bits 2..0, packet in 18..3 and sync in 19, with bits 31..20 zero.
- R5: A sample with `smp_trig`=1 has status field 3'b110. Its packet bits 2..0 carry the true status, and its other packet bits and sync are unchanged.
- R6: `word_vld` is high for exactly the cycle after the clock edge that fills the last lane or performs a flush. `word_o` holds its value at all other times.
- R7: At the first clock edge with `cap_en` low and a partly filled word, that word is emitted with unfilled lanes at zero. No word is emitted when no lane is filled.
- R8: `width_sel` and `port_mode` are loaded only at edges where `cap_en` is low. Changes while `cap_en` is high have no effect on packing.
- R9: Port mode 01 (multiplexed), 11 (reserved), width 11, and port mode 10 (demultiplexed) with any width other than 8-bit are illegal. While the loaded configuration is illegal, `cfg_bad` is 1 and no sample is accepted. Port mode 00 is normal.
- R10: Cycles with `smp_vld` low, or with `cap_en` low, are not packed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en | input | 1 | Capture enable; low loads configuration and flushes |
| width_sel | input | 2 | Port width: 00=4, 01=8, 10=16, 11 reserved |
| port_mode | input | 2 | 00 normal, 01 multiplexed, 10 demultiplexed, 11 reserved |
| smp_vld | input | 1 | Trace sample present this cycle |
| smp_stat | input | 3 | Pipeline status of the sample |
| smp_pkt | input | 16 | Packet field (low 4/8/16 bits used per width) |
| smp_sync | input | 1 | Sync flag of the sample |
| smp_trig | input | 1 | Sample is the trigger cycle |
| word_o | output | 32 | Last emitted capture word |
| word_vld | output | 1 | One-cycle strobe for a new word |
| cfg_bad | output | 1 | Loaded configuration is illegal |

## Verification
The bench builds the block with its default 16-bit packet field and 32-bit word. At these values all three lane layouts are in reach, and a trigger sample in 16-bit mode has its upper packet bits fully visible in the word. Random legal configurations are mixed with gaps in `smp_vld` and capture toggles at random points. Together these reach partial flushes from every lane position, back-to-back words in 16-bit mode and configuration changes attempted mid-capture. Directed steps cover the illegal port modes and trigger samples in each width.

// File: rtl/trc_pack_pkg.sv
package trc_pack_pkg;

  typedef enum logic [1:0] {
    W_NIB  = 2'b00,
    W_BYTE = 2'b01,
    W_HALF = 2'b10,
    W_RSV  = 2'b11
  } width_e;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_MUXED  = 2'b01,
    PM_DEMUX  = 2'b10,
    PM_RSV    = 2'b11
  } port_mode_e;

  typedef struct packed {
    width_e     w;
    port_mode_e m;
  } port_cfg_t;

  localparam logic [2:0] TRIG_CODE = 3'b110;
  localparam int         STAT_W    = 3;

  // Number of trace cycles that share one capture word.
  function automatic logic [1:0] lanes_per_word(width_e w);
    case (w)
      W_NIB:   return 2'd3;
      W_BYTE:  return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  // Packet bits kept per cycle for a given width.
  function automatic int pkt_bits(width_e w);
    case (w)
      W_NIB:   return 4;
      W_BYTE:  return 8;
      default: return 16;
    endcase
  endfunction

  // Bit offset of a lane inside the word.
  function automatic logic [4:0] lane_offset(width_e w, logic [1:0] lane);
    case (w)
      W_NIB:   return {lane, 3'b000};
      W_BYTE:  return 5'({lane, 3'b000}) + 5'({lane, 2'b00});
      default: return 5'd0;
    endcase
  endfunction

  // Only normal mode with a defined width, or demultiplexed at 8 bits.
  function automatic logic cfg_ok(port_cfg_t c);
    if (c.w == W_RSV) return 1'b0;
    case (c.m)
      PM_NORMAL: return 1'b1;
      PM_DEMUX:  return (c.w == W_BYTE);
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/trc_cfg_guard.sv
module trc_cfg_guard
  import trc_pack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_en,
  input  logic [1:0] width_sel,
  input  logic [1:0] port_mode,
  output port_cfg_t  cfg_q,
  output logic       cfg_legal
);

  port_cfg_t cfg_in;
  logic      cfg_load;

  assign cfg_in.w  = width_e'(width_sel);
  assign cfg_in.m  = port_mode_e'(port_mode);
  assign cfg_load  = !cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.w <= W_HALF;
      cfg_q.m <= PM_NORMAL;
    end else if (cfg_load) begin
      cfg_q <= cfg_in;
    end
  end

  assign cfg_legal = cfg_ok(cfg_q);

  // R8: configuration held while capture runs
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> $stable(cfg_q));

endmodule

// File: rtl/trc_slot_encoder.sv
module trc_slot_encoder
  import trc_pack_pkg::*;
#(
  parameter int PKT_W   = 16,
  parameter int FIELD_W = PKT_W + 4
)(
  input  width_e             w,
  input  logic [STAT_W-1:0]  stat,
  input  logic [PKT_W-1:0]   pkt,
  input  logic               sync,
  input  logic               trig,
  output logic [FIELD_W-1:0] field
);

  localparam int N_VAR = 3;

  logic [STAT_W-1:0]  stat_eff;
  logic [PKT_W-1:0]   pkt_eff;
  logic [FIELD_W-1:0] variant [N_VAR];

  // Trigger: reserved code in status, true status moved to packet low bits.
  always_comb begin
    stat_eff = trig ? TRIG_CODE : stat;
    pkt_eff  = pkt;
    if (trig) pkt_eff[STAT_W-1:0] = stat;
  end

  for (genvar gi = 0; gi < N_VAR; gi++) begin : g_var
    localparam int PW = 4 << gi;
    assign variant[gi] = FIELD_W'({sync, pkt_eff[PW-1:0], stat_eff});
  end

  always_comb begin
    case (w)
      W_NIB:   field = variant[0];
      W_BYTE:  field = variant[1];
      W_HALF:  field = variant[2];
      default: field = '0;
    endcase
  end

  // R5: trigger marking visible in the encoded status
  always_comb begin
    if (trig && w != W_RSV)
      a_trig_code_r5: assert (field[STAT_W-1:0] == TRIG_CODE);
  end

endmodule

// File: rtl/trc_word_accum.sv
module trc_word_accum
  import trc_pack_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int FIELD_W = 20
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic               accept,
  input  width_e             w,
  input  logic [FIELD_W-1:0] field,
  output logic [WORD_W-1:0]  word_q,
  output logic               word_vld_q,
  output logic               emit_evt,
  output logic [1:0]         lane_q
);

  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] placed;
  logic [WORD_W-1:0] emit_word;
  logic [1:0]        last_lane;
  logic              fill_last;
  logic              flush_evt;

  assign last_lane = lanes_per_word(w) - 2'd1;
  assign placed    = WORD_W'(field) << lane_offset(w, lane_q);
  assign fill_last = accept && (lane_q == last_lane);
  assign flush_evt = !cap_en && (lane_q != 2'd0);
  assign emit_evt  = fill_last || flush_evt;
  assign emit_word = accept ? (acc_q | placed) : acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lane_q <= 2'd0;
    end else if (!cap_en) begin
      acc_q  <= '0;
      lane_q <= 2'd0;
    end else if (accept) begin
      if (fill_last) begin
        acc_q  <= '0;
        lane_q <= 2'd0;
      end else begin
        acc_q  <= acc_q | placed;
        lane_q <= lane_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= '0;
      word_vld_q <= 1'b0;
    end else begin
      word_vld_q <= emit_evt;
      if (emit_evt) word_q <= emit_word;
    end
  end

  // R2: lane index stays below the lane count of the width
  p_lane_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lane_q < lanes_per_word(w));

  // R6: strobe follows an emit event by one cycle
  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    emit_evt |=> word_vld_q);

  // R6: no strobe and word held without an emit event
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !emit_evt |=> (!word_vld_q && $stable(word_q)));

  // R7: partial word always flushed when capture drops
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && lane_q != 2'd0) |=> word_vld_q);

  // R7: lanes empty while capture is off
  p_idle_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> lane_q == 2'd0);

endmodule

// File: rtl/trc_cycle_packer.sv
module trc_cycle_packer
  import trc_pack_pkg::*;
#(
  parameter int PKT_W  = 16,
  parameter int WORD_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        width_sel,
  input  logic [1:0]        port_mode,
  input  logic              smp_vld,
  input  logic [2:0]        smp_stat,
  input  logic [PKT_W-1:0]  smp_pkt,
  input  logic              smp_sync,
  input  logic              smp_trig,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld,
  output logic              cfg_bad
);

  localparam int FIELD_W = PKT_W + STAT_W + 1;

  port_cfg_t          cfg_q;
  logic               cfg_legal;
  logic               accept;
  logic [FIELD_W-1:0] field;
  logic               emit_evt;
  logic [1:0]         lane_q;

  trc_cfg_guard u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .width_sel (width_sel),
    .port_mode (port_mode),
    .cfg_q     (cfg_q),
    .cfg_legal (cfg_legal)
  );

  assign accept  = cap_en && smp_vld && cfg_legal;
  assign cfg_bad = !cfg_legal;

  trc_slot_encoder #(.PKT_W(PKT_W), .FIELD_W(FIELD_W)) u_enc (
    .w     (cfg_q.w),
    .stat  (smp_stat),
    .pkt   (smp_pkt),
    .sync  (smp_sync),
    .trig  (smp_trig),
    .field (field)
  );

  trc_word_accum #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .accept     (accept),
    .w          (cfg_q.w),
    .field      (field),
    .word_q     (word_o),
    .word_vld_q (word_vld),
    .emit_evt   (emit_evt),
    .lane_q     (lane_q)
  );

  // R9: nothing packed while the configuration is illegal
  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |=> (lane_q == 2'd0 && !word_vld));

  // R10: idle sample cycles do not advance the lane
  p_idle_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !smp_vld) |=> $stable(lane_q));

endmodule

// File: tb/tb_trc_cycle_packer.sv
module tb_trc_cycle_packer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_en = 1'b0;
  logic [1:0]  width_sel = 2'b10;
  logic [1:0]  port_mode = 2'b00;
  logic        smp_vld = 1'b0;
  logic [2:0]  smp_stat = '0;
  logic [15:0] smp_pkt = '0;
  logic        smp_sync = 1'b0;
  logic        smp_trig = 1'b0;
  logic [31:0] word_o;
  logic        word_vld;
  logic        cfg_bad;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  int          m_w = 2;
  int          m_m = 0;
  int          m_lane = 0;
  logic [31:0] m_acc = '0;
  logic [31:0] m_last = '0;

  always #5 clk = ~clk;

  trc_cycle_packer dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .width_sel(width_sel),
    .port_mode(port_mode), .smp_vld(smp_vld), .smp_stat(smp_stat),
    .smp_pkt(smp_pkt), .smp_sync(smp_sync), .smp_trig(smp_trig),
    .word_o(word_o), .word_vld(word_vld), .cfg_bad(cfg_bad)
  );

  function automatic bit legal(int w, int m);
    if (w == 3) return 1'b0;
    if (m == 0) return 1'b1;
    if (m == 2) return (w == 1);
    return 1'b0;
  endfunction

  function automatic int n_lanes(int w);
    return (w == 0) ? 3 : (w == 1) ? 2 : 1;
  endfunction

  function automatic int lane_w(int w);
    return (w == 0) ? 8 : (w == 1) ? 12 : 20;
  endfunction

  function automatic logic [31:0] lane_val(int w, logic [2:0] st,
      logic [15:0] pk, logic sy, logic tg);
    int          pw;
    logic [2:0]  s;
    logic [15:0] p;
    logic [31:0] r;
    pw = (w == 0) ? 4 : (w == 1) ? 8 : 16;
    s  = tg ? 3'd6 : st;
    p  = tg ? ((pk & 16'hFFF8) | {13'd0, st}) : pk;
    p  = p & 16'((32'd1 << pw) - 1);
    r  = {29'd0, s} | ({16'd0, p} << 3) | (32'(sy) << (pw + 3));
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One clock: drive, advance the model, sample after the edge.
  task automatic cyc(string tag, bit en, bit vld, int w, int m,
      logic [2:0] st, logic [15:0] pk, bit sy, bit tg);
    bit          emit;
    logic [31:0] ew;
    cap_en = en; smp_vld = vld; width_sel = 2'(w); port_mode = 2'(m);
    smp_stat = st; smp_pkt = pk; smp_sync = sy; smp_trig = tg;
    emit = 1'b0; ew = m_acc;
    if (!en) begin
      if (m_lane != 0) emit = 1'b1;
      m_lane = 0; m_acc = '0; m_w = w; m_m = m;
    end else if (vld && legal(m_w, m_m)) begin
      m_acc = m_acc | (lane_val(m_w, st, pk, sy, tg) << (m_lane * lane_w(m_w)));
      m_lane++;
      if (m_lane == n_lanes(m_w)) begin
        emit = 1'b1; ew = m_acc; m_lane = 0; m_acc = '0;
      end
    end
    if (emit) m_last = ew;
    @(posedge clk);
    #1;
    check({tag, " vld"}, {31'd0, word_vld}, {31'd0, emit});
    check({tag, " word"}, word_o, m_last);
    check({tag, " cfg_bad"}, {31'd0, cfg_bad}, {31'd0, !legal(m_w, m_m)});
  endtask

  initial begin
    #(10 * 150000);
    n_bad++;
    $display("FAIL watchdog: got hung expected done");
    if (!done) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_7A11));
    #23;
    check("R1 reset vld", {31'd0, word_vld}, 32'd0);
    check("R1 reset word", word_o, 32'd0);
    check("R1 reset cfg_bad", {31'd0, cfg_bad}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: default 16-bit normal config packs without loading
    cyc("R1 default", 1, 1, 2, 0, 3'd5, 16'hA5C3, 1, 0);
    // R4: back-to-back 16-bit words
    for (int i = 0; i < 6; i++)
      cyc("R4 half", 1, 1, 2, 0, 3'(i), 16'($urandom), 1'($urandom), 0);
    cyc("R4 cfg nib", 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: three 4-bit cycles per word, directed
    cyc("R2 nib", 1, 1, 0, 0, 3'd1, 16'hFFF2, 1, 0);
    cyc("R2 nib", 1, 1, 0, 0, 3'd7, 16'h000F, 0, 0);
    cyc("R2 nib", 1, 1, 0, 0, 3'd3, 16'h1238, 1, 0);
    // R8: width change while enabled ignored
    cyc("R8 frozen", 1, 1, 2, 1, 3'd2, 16'h0005, 0, 0);
    cyc("R8 frozen", 1, 1, 1, 0, 3'd4, 16'h000A, 1, 0);
    // R7: flush after two lanes
    cyc("R7 flush2", 0, 0, 1, 2, 0, 0, 0, 0);
    // R3: 8-bit demux
    cyc("R3 byte", 1, 1, 1, 2, 3'd6, 16'hBEEF, 1, 0);
    cyc("R3 byte", 1, 1, 1, 2, 3'd2, 16'h1234, 0, 0);
    // R10: idle cycles and flush of one lane
    cyc("R10 gap", 1, 1, 1, 2, 3'd3, 16'h00C7, 1, 0);
    cyc("R10 gap", 1, 0, 1, 2, 3'd7, 16'hFFFF, 1, 1);
    cyc("R7 flush1", 0, 0, 1, 2, 0, 0, 0, 0);
    cyc("R7 noflush", 0, 0, 0, 0, 0, 0, 0, 0);
    // R5: trigger in every width
    cyc("R5 trig nib", 1, 1, 0, 0, 3'd5, 16'h000F, 0, 1);
    cyc("R7 flush tr", 0, 0, 1, 0, 0, 0, 0, 0);
    cyc("R5 trig byte", 1, 1, 1, 0, 3'd3, 16'h00A8, 1, 1);
    cyc("R5 trig byte", 1, 1, 1, 0, 3'd0, 16'h0011, 0, 0);
    cyc("R5 cfg", 0, 0, 2, 0, 0, 0, 0, 0);
    cyc("R5 trig half", 1, 1, 2, 0, 3'd1, 16'hF0F8, 1, 1);
    // R9: illegal modes
    cyc("R9 mux", 0, 0, 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++)
      cyc("R9 mux quiet", 1, 1, 1, 1, 3'(i), 16'($urandom), 1, 0);
    cyc("R9 demux nib", 0, 0, 0, 2, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++)
      cyc("R9 demux quiet", 1, 1, 0, 2, 3'(i), 16'($urandom), 0, 0);
    cyc("R9 rsv w", 0, 0, 3, 0, 0, 0, 0, 0);
    cyc("R9 rsv quiet", 1, 1, 3, 0, 3'd1, 16'h1, 1, 0);
    // random mix of legal configs, gaps, triggers and capture drops
    for (int r = 0; r < 3000; r++) begin
      int sel;
      int w;
      int m;
      sel = int'($urandom % 4);
      w = (sel == 3) ? 1 : sel;
      m = (sel == 3) ? 2 : 0;
      if (($urandom % 17) == 0)
        cyc("R7 rnd off", 0, 0, w, m, 0, 0, 0, 0);
      else
        cyc("R3 rnd", 1, ($urandom % 4) != 0, int'($urandom % 4),
            int'($urandom % 4), 3'($urandom), 16'($urandom),
            1'($urandom), ($urandom % 9) == 0);
    end
    cyc("R7 end", 0, 0, 2, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule